// File: doc/BRIEF.md
# Way-Rotated Banked Cache Data Array

This block is the data store of a four-way set-associative cache. It holds each 256-bit line as eight 32-bit words and spreads them over eight single-port word banks. The four ways are rotated across the banks. For any doubleword index, the four ways therefore sit in four different bank pairs, all at the same bank address. A lookup enables all eight banks once and returns that doubleword for every way, and the tag compare outside the block picks one of them.

Four request kinds share one request port. A lookup reads one doubleword from every way. A sequential read, used once the hit way is known, enables only the one bank pair that holds the wanted doubleword. An eviction read returns a whole line in one cycle, and a fill writes a whole line in one cycle. Each bank can be built with seven extra stored bits per word for check codes. This block stores those bits and returns them unchanged; it does not generate or check them. Read results appear one clock after the request.

Top module: `cache_data_array`

## Requirements
- R1: After a synchronous active-low reset, and before any request, `bank_en` is zero and `lookup_data`, `seq_data` and `evict_data` are all zero.
- R2: A request is taken only when `req_valid` is 1. When it is 0, `bank_en` is zero, no stored word changes (even if `req_op` = 3 and `fill_data` changes), and all read outputs keep their last values.
- R3: The request code `req_op` is 0 for a lookup, 1 for a sequential read, 2 for an eviction read and 3 for a fill. A lookup drives `bank_en` = 8'hFF in the same cycle.
- R4: One cycle after a lookup of set s and doubleword k, `lookup_data[64*w +: 64]` equals bits `[64*k +: 64]` of the line stored in way w of set s, for every way w.
- R5: For a sequential read of doubleword k in way w, `bank_en` has exactly the two bits 2p and 2p+1 set in the same cycle, where p = (k + w) mod 4.
- R6: One cycle after a sequential read of set s, doubleword k and way w, `seq_data` equals bits `[64*k +: 64]` of that line.
- R7: An eviction read drives `bank_en` = 8'hFF, and one cycle later `evict_data` holds the whole 256-bit line of the requested set and way.
- R8: A fill drives `bank_en` = 8'hFF and stores all 256 bits of `fill_data` as the line of the requested set and way in one cycle. Other ways and sets are left unchanged, and an eviction read in the very next cycle already returns the new line.
- R9: With `ECC_EN` = 1, each word is 39 bits wide. Word j of a line is carried at bits `[39*j +: 39]` of `fill_data` and `evict_data`, doublewords are 78 bits wide, and every bit is returned exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 lookup, 1 sequential read, 2 eviction read, 3 fill |
| set_index | input | SET_W | Set (line) address shared by all banks |
| dword_index | input | 2 | Doubleword within the line (lookup, sequential read) |
| way | input | 2 | Way for sequential read, eviction read and fill |
| fill_data | input | 8*BANK_W | Line to be written by a fill, word j at [BANK_W*j +: BANK_W] |
| lookup_data | output | 8*BANK_W | Doubleword of every way, way w at [2*BANK_W*w +: 2*BANK_W] |
| seq_data | output | 2*BANK_W | Doubleword returned by a sequential read |
| evict_data | output | 8*BANK_W | Line returned by an eviction read |
| bank_en | output | 8 | Per-bank enable of the current request |

## Verification
`bank_en` depends only on the current request, so the bench checks it one time step after it drives the inputs, still ahead of the clock edge. Lookup, sequential and eviction results come from the bank output registers. They are checked at the falling edge that follows the capturing rising edge, which is exactly one cycle after the request, and the bench checks only the output that belongs to the request kind. A fill shows no result of its own. The bench confirms it through later lookups, sequential reads and eviction reads, and one of these eviction reads comes in the very next cycle. A second instance built with the check bits enabled sees the same requests and is compared against its own 312-bit line model.

// File: rtl/cda_pkg.sv
// Shared constants, request codes and the way-rotation arithmetic of the
// banked cache data array. The way count and the number of doublewords per
// line are fixed at four, so all rotation arithmetic is modulo 4.
package cda_pkg;
    localparam int WAYS    = 4;
    localparam int DWS     = 4;          // doublewords per line
    localparam int NBANK   = 2 * DWS;    // one bank per 32-bit word of a line
    localparam int IDX_W   = 2;          // width of way and doubleword indices

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_SEQ    = 2'd1,
        OP_EVICT  = 2'd2,
        OP_FILL   = 2'd3
    } op_e;

    // Bank pair that holds doubleword dw of way w.
    function automatic logic [IDX_W-1:0] pair_of(input logic [IDX_W-1:0] dw,
                                                 input logic [IDX_W-1:0] w);
        return dw + w;
    endfunction

    // Doubleword of way w that lives in bank pair p (inverse of pair_of).
    function automatic logic [IDX_W-1:0] dw_in_pair(input logic [IDX_W-1:0] p,
                                                    input logic [IDX_W-1:0] w);
        return p - w;
    endfunction
endpackage

// File: rtl/cda_bank.sv
// One single-port word bank of the data array.
// Holds four sub-entries per set (one per doubleword slot), addressed as
// {set, sub}. A read is registered and its result stays until the next read.
// Assumes write enable is only raised together with bank enable.
module cda_bank #(
    parameter int BANK_W = 32,
    parameter int SET_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [1:0]        sub,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata
);
    localparam int DEPTH = (1 << SET_W) * 4;
    localparam int AW    = SET_W + 2;

    logic [BANK_W-1:0] mem [DEPTH];
    logic [AW-1:0]     addr;

    assign addr = {set_idx, sub};

    // Store the word on an enabled write.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // Capture the addressed word on an enabled read; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[addr];
        end
    end

    // R8
    write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> en);
endmodule

// File: rtl/cda_addr_gen.sv
// Request decode for the banked data array: per-bank enable, write enable,
// sub-entry select and write word. Purely combinational.
// Lookups and sequential reads use sub-entry = requested doubleword in all
// banks; evictions and fills use, per bank pair, the doubleword of the
// requested way that the rotation placed there.
module cda_addr_gen
    import cda_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic                         req_valid,
    input  op_e                          req_op,
    input  logic [IDX_W-1:0]             dword_index,
    input  logic [IDX_W-1:0]             way,
    input  logic [NBANK-1:0][BANK_W-1:0] fill_words,
    output logic [NBANK-1:0]             bank_en,
    output logic [NBANK-1:0]             bank_we,
    output logic [NBANK-1:0][1:0]        bank_sub,
    output logic [NBANK-1:0][BANK_W-1:0] bank_wdata
);
    logic             line_op;
    logic [IDX_W-1:0] seq_pair;

    // Whole-line operations address a different sub-entry in each bank pair.
    assign line_op  = (req_op == OP_EVICT) || (req_op == OP_FILL);
    // Only pair needed by a sequential read.
    assign seq_pair = pair_of(dword_index, way);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [IDX_W-1:0] PAIR = IDX_W'(b / 2);
        localparam logic             HALF = 1'(b % 2);
        logic [IDX_W-1:0] k_line;

        // Doubleword of the requested way that sits in this pair.
        assign k_line        = dw_in_pair(PAIR, way);
        assign bank_sub[b]   = line_op ? k_line : dword_index;
        assign bank_en[b]    = req_valid && ((req_op != OP_SEQ) || (seq_pair == PAIR));
        assign bank_we[b]    = req_valid && (req_op == OP_FILL);
        assign bank_wdata[b] = fill_words[{k_line, HALF}];
    end
endmodule

// File: rtl/cda_read_mux.sv
// Undoes the way rotation on the registered bank outputs.
// Assumes rd_dw and rd_way are the doubleword and way of the read whose
// result the banks currently hold.
module cda_read_mux
    import cda_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic [IDX_W-1:0]               rd_dw,
    input  logic [IDX_W-1:0]               rd_way,
    input  logic [NBANK-1:0][BANK_W-1:0]   bank_q,
    output logic [WAYS-1:0][2*BANK_W-1:0]  lookup_words,
    output logic [2*BANK_W-1:0]            seq_word,
    output logic [DWS-1:0][2*BANK_W-1:0]   evict_words
);
    logic [IDX_W-1:0] seq_pair;

    // One doubleword per way: way w sits in pair (dw + w).
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [IDX_W-1:0] p;
        assign p               = pair_of(rd_dw, IDX_W'(w));
        assign lookup_words[w] = {bank_q[{p, 1'b1}], bank_q[{p, 1'b0}]};
    end

    // Doubleword from the single pair a sequential read enabled.
    assign seq_pair = pair_of(rd_dw, rd_way);
    assign seq_word = {bank_q[{seq_pair, 1'b1}], bank_q[{seq_pair, 1'b0}]};

    // Whole line: doubleword k of the way sits in pair (k + way).
    for (genvar k = 0; k < DWS; k++) begin : g_dw
        logic [IDX_W-1:0] p;
        assign p              = pair_of(IDX_W'(k), rd_way);
        assign evict_words[k] = {bank_q[{p, 1'b1}], bank_q[{p, 1'b0}]};
    end
endmodule

// File: rtl/cache_data_array.sv
// Four-way cache data array of eight word banks with way rotation.
// One request per cycle; read results one cycle later and held until the
// next read. Check bits (ECC_EN) are stored and returned, never computed.
// Assumes a fill and a read are never issued in the same cycle (the single
// request port makes this so).
module cache_data_array
    import cda_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter bit ECC_EN   = 1'b0,
    parameter int ECC_BITS = 7,
    parameter int SET_W    = 5,
    localparam int BANK_W  = WORD_W + (ECC_EN ? ECC_BITS : 0),
    localparam int DW_W    = 2 * BANK_W,
    localparam int LINE_W  = NBANK * BANK_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [SET_W-1:0]      set_index,
    input  logic [1:0]            dword_index,
    input  logic [1:0]            way,
    input  logic [LINE_W-1:0]     fill_data,
    output logic [WAYS*DW_W-1:0]  lookup_data,
    output logic [DW_W-1:0]       seq_data,
    output logic [LINE_W-1:0]     evict_data,
    output logic [NBANK-1:0]      bank_en
);
    op_e                          op;
    logic [NBANK-1:0][BANK_W-1:0] fill_words;
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][1:0]        bank_sub;
    logic [NBANK-1:0][BANK_W-1:0] bank_wdata;
    logic [NBANK-1:0][BANK_W-1:0] bank_q;
    logic [WAYS-1:0][DW_W-1:0]    lookup_words;
    logic [DWS-1:0][DW_W-1:0]     evict_words;
    logic [IDX_W-1:0]             rd_dw;
    logic [IDX_W-1:0]             rd_way;

    assign op         = op_e'(req_op);
    assign fill_words = fill_data;

    cda_addr_gen #(.BANK_W(BANK_W)) u_addr (
        .req_valid   (req_valid),
        .req_op      (op),
        .dword_index (dword_index),
        .way         (way),
        .fill_words  (fill_words),
        .bank_en     (bank_en),
        .bank_we     (bank_we),
        .bank_sub    (bank_sub),
        .bank_wdata  (bank_wdata)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cda_bank #(.BANK_W(BANK_W), .SET_W(SET_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (bank_en[b]),
            .we      (bank_we[b]),
            .set_idx (set_index),
            .sub     (bank_sub[b]),
            .wdata   (bank_wdata[b]),
            .rdata   (bank_q[b])
        );
    end

    // Remember which doubleword and way the banks are returning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_dw  <= '0;
            rd_way <= '0;
        end else if (req_valid && op != OP_FILL) begin
            rd_dw  <= dword_index;
            rd_way <= way;
        end
    end

    cda_read_mux #(.BANK_W(BANK_W)) u_mux (
        .rd_dw        (rd_dw),
        .rd_way       (rd_way),
        .bank_q       (bank_q),
        .lookup_words (lookup_words),
        .seq_word     (seq_data),
        .evict_words  (evict_words)
    );

    assign lookup_data = lookup_words;
    assign evict_data  = evict_words;

    // R2
    idle_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (bank_en == '0));
    // R3
    lookup_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_LOOKUP) |-> (&bank_en));
    // R5
    seq_pair_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_SEQ) |->
            ($countones(bank_en) == 2 && bank_en inside {8'h03, 8'h0C, 8'h30, 8'hC0}));
    // R8
    fill_writes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_FILL) |-> (&bank_we));
    // R8
    fill_then_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_EVICT && $past(req_valid && op == OP_FILL)
         && $past(set_index) == set_index && $past(way) == way)
        |=> (evict_data == $past(fill_data, 2)));
endmodule

// File: tb/sim_cache_data_array.sv
// Bench: behavioural line model per set and way, compared on every request.
module sim_cache_data_array;
    localparam int SETS = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_op = 2'd0;
    logic [4:0]   set_index = '0;
    logic [1:0]   dword_index = '0;
    logic [1:0]   way = '0;
    logic [255:0] fill_data = '0;
    logic [311:0] fill_data1 = '0;

    logic [255:0] lookup_data, evict_data;
    logic [63:0]  seq_data;
    logic [7:0]   bank_en;
    logic [311:0] lookup_data1, evict_data1;
    logic [77:0]  seq_data1;
    logic [7:0]   bank_en1;

    logic [255:0] m0 [SETS][4];
    logic [311:0] m1 [SETS][4];

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cache_data_array u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .set_index(set_index), .dword_index(dword_index), .way(way),
        .fill_data(fill_data), .lookup_data(lookup_data), .seq_data(seq_data),
        .evict_data(evict_data), .bank_en(bank_en)
    );

    cache_data_array #(.ECC_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .set_index(set_index), .dword_index(dword_index), .way(way),
        .fill_data(fill_data1), .lookup_data(lookup_data1), .seq_data(seq_data1),
        .evict_data(evict_data1), .bank_en(bank_en1)
    );

    task automatic chk(input string req, input logic [319:0] act, input logic [319:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic [7:0] exp_en(input logic [1:0] op, input logic [1:0] k,
                                          input logic [1:0] w);
        logic [1:0] p;
        p = k + w;
        return (op == 2'd1) ? (8'b11 << (2 * p)) : 8'hFF;
    endfunction

    // Issue one request at a falling edge; check results one cycle later.
    task automatic run_op(input logic [1:0] op, input int s, input logic [1:0] k,
                          input logic [1:0] w);
        logic [319:0] r;
        req_valid = 1'b1; req_op = op; set_index = 5'(s); dword_index = k; way = w;
        if (op == 2'd3) begin
            fill_data = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom};
            r = {$urandom, $urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom, $urandom, $urandom};
            fill_data1 = r[311:0];
        end
        #1;
        chk(op == 2'd1 ? "R5 bank_en" : (op == 2'd0 ? "R3 bank_en" :
            (op == 2'd2 ? "R7 bank_en" : "R8 bank_en")), 320'(bank_en), 320'(exp_en(op, k, w)));
        chk("R9 bank_en ecc", 320'(bank_en1), 320'(exp_en(op, k, w)));
        @(negedge clk);
        case (op)
            2'd0: for (int wi = 0; wi < 4; wi++) begin
                chk("R4 lookup", 320'(lookup_data[wi*64 +: 64]), 320'(m0[s][wi][k*64 +: 64]));
                chk("R9 lookup ecc", 320'(lookup_data1[wi*78 +: 78]), 320'(m1[s][wi][k*78 +: 78]));
            end
            2'd1: begin
                chk("R6 seq", 320'(seq_data), 320'(m0[s][w][k*64 +: 64]));
                chk("R9 seq ecc", 320'(seq_data1), 320'(m1[s][w][k*78 +: 78]));
            end
            2'd2: begin
                chk("R7 evict", 320'(evict_data), 320'(m0[s][w]));
                chk("R9 evict ecc", 320'(evict_data1), 320'(m1[s][w]));
            end
            default: begin
                m0[s][w] = fill_data;
                m1[s][w] = fill_data1;
            end
        endcase
    endtask

    task automatic idle();
        req_valid = 1'b0;
        #1;
        chk("R2 idle bank_en", 320'(bank_en), 320'(0));
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog R1-timeout actual=running expected=finished");
        summary();
    end

    initial begin
        logic [255:0] hold_lk;
        logic [255:0] hold_fd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 bank_en", 320'(bank_en), 320'(0));
        chk("R1 lookup", 320'(lookup_data), 320'(0));
        chk("R1 seq", 320'(seq_data), 320'(0));
        chk("R1 evict", 320'(evict_data), 320'(0));
        chk("R1 evict ecc", 320'(evict_data1), 320'(0));
        @(negedge clk);

        // R8: fill every way of three sets
        foreach (m0[s]) if (s == 0 || s == 7 || s == 31)
            for (int w = 0; w < 4; w++) run_op(2'd3, s, 2'd0, 2'(w));

        // R3/R4: lookups of every doubleword
        for (int s = 0; s < 32; s += 7) begin
            int ss;
            ss = (s == 28) ? 31 : s;
            if (ss == 0 || ss == 7 || ss == 31)
                for (int k = 0; k < 4; k++) run_op(2'd0, ss, 2'(k), 2'd0);
        end

        // R5/R6: sequential reads of every doubleword of every way
        for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++) run_op(2'd1, 7, 2'(k), 2'(w));

        // R7: eviction reads of every way
        for (int w = 0; w < 4; w++) run_op(2'd2, 31, 2'd0, 2'(w));

        // R8: refill one way, neighbours untouched, back-to-back evict
        run_op(2'd3, 7, 2'd0, 2'd2);
        run_op(2'd2, 7, 2'd0, 2'd2);
        run_op(2'd2, 7, 2'd0, 2'd1);
        run_op(2'd2, 0, 2'd0, 2'd2);
        run_op(2'd0, 7, 2'd3, 2'd0);

        // R2: outputs hold while idle; an invalid fill changes nothing
        run_op(2'd0, 0, 2'd2, 2'd0);
        hold_lk = lookup_data;
        req_op = 2'd3; set_index = 5'd0; way = 2'd1;
        hold_fd = {$urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom};
        fill_data = hold_fd;
        for (int i = 0; i < 3; i++) begin
            idle();
            chk("R2 lookup held", 320'(lookup_data), 320'(hold_lk));
        end
        run_op(2'd2, 0, 2'd0, 2'd1);
        run_op(2'd1, 0, 2'd1, 2'd1);

        idle();
        summary();
    end
endmodule